// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Sequencer

This block is the sequencing core of a four-channel DMA engine. A request that has already been qualified upstream (mask, polarity and mode checks are done elsewhere) arrives with its channel number, transfer kind, repeat mode and a memory-to-memory flag. The sequencer raises a hold request to the host processor. It waits for the hold acknowledge, then drives the active-low memory and I/O read and write strobes. When a transfer finishes, it decrements the word count of the channel concerned.

Device transfers run through a four-state active cycle. A memory-to-memory copy runs through its own eight-state path: a read phase captures a byte into a holding register, and a write phase then drives that byte back onto the bus. A bus-wait input stretches the strobe phase of either path. A transfer run ends on any of these conditions:
- terminal count, which is the word counter wrapping from zero to all ones;
- the external end-of-process input going low;
- the end of a single transfer;
- a dropped request in repeat mode;
- an illegal transfer kind.

The host-side registers are reduced to a simple count-load port, and that port is accepted only while the sequencer is idle.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, hreq is low, all four strobes and all dackN bits are high, and tcPulse and dataOe are low.
- R2: A request in idle raises hreq on the next cycle. No strobe goes low while hlda has not been given.
- R3: If reqValid falls while the sequencer waits for hlda, hreq falls on the next cycle and no transfer takes place.
- R4: Transfer kind is encoded as 01 = I/O to memory (iorN and memwN low together) and 10 = memory to I/O (memrN and iowN low together). During the cycle, dackN[channel] is low. Kind 00 (verify) drives no strobe but still decrements the count.
- R5: With busWait high, the sequencer holds the strobe phase. The strobes stay low for 2 cycles plus one cycle per extra cycle of busWait.
- R6: In single mode (demandMode=0), exactly one transfer is made, after which hreq falls.
- R7: In demand mode, a channel loaded with count N makes N+1 transfers. The last one wraps the counter to all ones, and tcPulse is high for exactly one cycle, in the first idle cycle.
- R8: In demand mode, the run stops after the current transfer if reqValid falls or eopInN is seen low at any point in the run. No tcPulse occurs in that case.
- R9: Kind 11 is illegal. After hlda, the sequencer returns to idle with no strobe and no count change.
- R10: With memToMem=1, memrN goes low first. The byte on dataIn when the read phase ends is held and driven on dataOut, with dataOe high, while memwN is low. Only channel 1's count is decremented, and the copy repeats until channel 1 reaches terminal count.
- R11: At most one read strobe (memrN, iorN) and one write strobe (memwN, iowN) are low at a time, and at most one dackN bit is low.
- R12: A count load (loadEn) takes effect only while the sequencer is idle. A load attempted during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Qualified channel request |
| reqChan | input | 2 | Requesting channel |
| xferKind | input | 2 | 00 verify, 01 I/O to memory, 10 memory to I/O, 11 illegal |
| demandMode | input | 1 | 1 = repeat transfers while requested, 0 = single transfer |
| memToMem | input | 1 | 1 = memory-to-memory copy into channel 1 |
| hlda | input | 1 | Hold acknowledge from host |
| busWait | input | 1 | High extends the strobe phase |
| eopInN | input | 1 | Active-low external end of process |
| loadEn | input | 1 | Load word count (accepted only when idle) |
| loadChan | input | 2 | Channel whose count is loaded |
| loadValue | input | 16 | Count value to load |
| dataIn | input | 8 | Data bus input for the copy read phase |
| hreq | output | 1 | Hold request to host |
| memrN | output | 1 | Memory read strobe, active low |
| memwN | output | 1 | Memory write strobe, active low |
| iorN | output | 1 | I/O read strobe, active low |
| iowN | output | 1 | I/O write strobe, active low |
| dackN | output | 4 | Per-channel acknowledge, active low |
| tcPulse | output | 1 | One-cycle terminal count indication |
| dataOut | output | 8 | Held byte driven in the copy write phase |
| dataOe | output | 1 | Drive enable for dataOut |

## Verification
The assertions check the following on every cycle:
- strobe exclusivity and the one-hot acknowledge;
- that no strobe is driven without hold;
- that hold is released when a request is withdrawn;
- that wait states are held;
- that the counter wraps from zero to all ones;
- that the copied byte stays stable while it is driven.

Other behaviours can be shown only by the bench's scenarios, because they depend on whole transfer sequences:
- the exact transfer counts for a loaded value;
- the stop after a dropped request or an end-of-process pulse;
- the rejection of a load made mid-transfer;
- which byte the copy captures.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [CH_W-1:0] COPY_DST_CH = CH_W'(1);

  typedef enum logic [1:0] {
    KIND_VERIFY = 2'b00,
    KIND_IO2MEM = 2'b01,
    KIND_MEM2IO = 2'b10,
    KIND_BAD    = 2'b11
  } xfer_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD,
    ST_A1, ST_A2, ST_A3, ST_A4,
    ST_M1, ST_M2, ST_M3, ST_M4, ST_M5, ST_M6, ST_M7, ST_M8
  } seq_state_e;

  typedef struct packed {
    logic            decCount;
    logic [CH_W-1:0] decChan;
    logic            latchData;
    logic            driveData;
    logic            allowLoad;
  } dp_ctl_t;
endpackage

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CH_W-1:0]    reqChan,
  input  logic [1:0]         xferKind,
  input  logic               demandMode,
  input  logic               memToMem,
  input  logic               hlda,
  input  logic               busWait,
  input  logic               eopInN,
  input  logic               cntZero,
  output logic               hreq,
  output logic               memrN,
  output logic               memwN,
  output logic               iorN,
  output logic               iowN,
  output logic [NUM_CH-1:0]  dackN,
  output logic               tcPulse,
  output dp_ctl_t            ctl
);
  seq_state_e state, stateNxt;
  logic [CH_W-1:0] chanQ;
  xfer_kind_e kindQ;
  logic demandQ, copyQ, eopSeen;
  logic ioActive, ioStrobe, endIo, endCopy;

  assign ioActive = (state == ST_A1) || (state == ST_A2) || (state == ST_A3) || (state == ST_A4);
  assign ioStrobe = (state == ST_A2) || (state == ST_A3);
  assign endIo   = cntZero || eopSeen || !eopInN || !demandQ || !reqValid;
  assign endCopy = cntZero || eopSeen || !eopInN;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNxt = ST_HOLD;
      ST_HOLD: begin
        if (!reqValid)             stateNxt = ST_IDLE;
        else if (hlda) begin
          if (copyQ)               stateNxt = ST_M1;
          else if (kindQ == KIND_BAD) stateNxt = ST_IDLE;
          else                     stateNxt = ST_A1;
        end
      end
      ST_A1: stateNxt = ST_A2;
      ST_A2: stateNxt = ST_A3;
      ST_A3: stateNxt = busWait ? ST_A3 : ST_A4;
      ST_A4: stateNxt = endIo ? ST_IDLE : ST_A1;
      ST_M1: stateNxt = ST_M2;
      ST_M2: stateNxt = ST_M3;
      ST_M3: stateNxt = busWait ? ST_M3 : ST_M4;
      ST_M4: stateNxt = ST_M5;
      ST_M5: stateNxt = ST_M6;
      ST_M6: stateNxt = ST_M7;
      ST_M7: stateNxt = busWait ? ST_M7 : ST_M8;
      ST_M8: stateNxt = endCopy ? ST_IDLE : ST_M1;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      chanQ   <= '0;
      kindQ   <= KIND_VERIFY;
      demandQ <= 1'b0;
      copyQ   <= 1'b0;
      eopSeen <= 1'b0;
      tcPulse <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && reqValid) begin
        chanQ   <= reqChan;
        kindQ   <= xfer_kind_e'(xferKind);
        demandQ <= demandMode;
        copyQ   <= memToMem;
      end
      if (state == ST_IDLE)  eopSeen <= 1'b0;
      else if (!eopInN)      eopSeen <= 1'b1;
      tcPulse <= ((state == ST_A4) || (state == ST_M8)) && cntZero;
    end
  end

  assign hreq  = (state != ST_IDLE);
  assign iorN  = !(ioStrobe && kindQ == KIND_IO2MEM);
  assign iowN  = !(ioStrobe && kindQ == KIND_MEM2IO);
  assign memrN = !((ioStrobe && kindQ == KIND_MEM2IO) || state == ST_M2 || state == ST_M3);
  assign memwN = !((ioStrobe && kindQ == KIND_IO2MEM) || state == ST_M6 || state == ST_M7);

  always_comb begin
    dackN = '1;
    if (ioActive) dackN[chanQ] = 1'b0;
  end

  always_comb begin
    ctl.decCount  = (state == ST_A4) || (state == ST_M8);
    ctl.decChan   = copyQ ? COPY_DST_CH : chanQ;
    ctl.latchData = (state == ST_M3) && !busWait;
    ctl.driveData = (state == ST_M5) || (state == ST_M6) || (state == ST_M7);
    ctl.allowLoad = (state == ST_IDLE);
  end

  // R11: strobe and acknowledge exclusivity
  p_one_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(!memrN && !iorN));
  p_one_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(!memwN && !iowN));
  p_dack_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~dackN));
  // R2: no strobe without hold request
  p_no_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !hreq |-> (memrN && memwN && iorN && iowN));
  // R3: withdrawn request releases hold
  p_drop_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !reqValid) |=> !hreq);
  // R5: wait holds the strobe phase
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_A3 && busWait) |=> (state == ST_A3));
  // R7: terminal count is reported in idle
  p_tc_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> !hreq);
endmodule

// File: rtl/dma_xfer_dpath.sv
module dma_xfer_dpath
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic              loadEn,
  input  logic [CH_W-1:0]   loadChan,
  input  logic [CNT_W-1:0]  loadValue,
  input  logic [DATA_W-1:0] dataIn,
  output logic              cntZero,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  logic [CNT_W-1:0] cnt [NUM_CH];
  logic [CNT_W-1:0] selCnt;
  logic [DATA_W-1:0] tempQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN)
        cnt[i] <= '0;
      else if (loadEn && ctl.allowLoad && loadChan == CH_W'(i))
        cnt[i] <= loadValue;
      else if (ctl.decCount && ctl.decChan == CH_W'(i))
        cnt[i] <= cnt[i] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              tempQ <= '0;
    else if (ctl.latchData) tempQ <= dataIn;
  end

  assign selCnt  = cnt[ctl.decChan];
  assign cntZero = (selCnt == '0);
  assign dataOut = tempQ;
  assign dataOe  = ctl.driveData;

  // R7: terminal count wraps the counter to all ones
  p_count_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.decCount && selCnt == '0) |=> (selCnt == '1));
  // R10: held byte is stable while driven
  p_temp_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.driveData |-> $stable(tempQ));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CH_W-1:0]   reqChan,
  input  logic [1:0]        xferKind,
  input  logic              demandMode,
  input  logic              memToMem,
  input  logic              hlda,
  input  logic              busWait,
  input  logic              eopInN,
  input  logic              loadEn,
  input  logic [CH_W-1:0]   loadChan,
  input  logic [CNT_W-1:0]  loadValue,
  input  logic [DATA_W-1:0] dataIn,
  output logic              hreq,
  output logic              memrN,
  output logic              memwN,
  output logic              iorN,
  output logic              iowN,
  output logic [NUM_CH-1:0] dackN,
  output logic              tcPulse,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  dp_ctl_t ctl;
  logic cntZero;

  dma_xfer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .xferKind(xferKind), .demandMode(demandMode), .memToMem(memToMem),
    .hlda(hlda), .busWait(busWait), .eopInN(eopInN), .cntZero(cntZero),
    .hreq(hreq), .memrN(memrN), .memwN(memwN), .iorN(iorN), .iowN(iowN),
    .dackN(dackN), .tcPulse(tcPulse), .ctl(ctl)
  );

  dma_xfer_dpath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadEn(loadEn), .loadChan(loadChan),
    .loadValue(loadValue), .dataIn(dataIn), .cntZero(cntZero),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/dma_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, demandMode = 0, memToMem = 0, hlda = 0, busWait = 0, eopInN = 1;
  logic loadEn = 0;
  logic [1:0] reqChan = 0, xferKind = 0, loadChan = 0;
  logic [15:0] loadValue = 0;
  logic [7:0] dataIn = 8'hA5;
  logic hreq, memrN, memwN, iorN, iowN, tcPulse, dataOe;
  logic [3:0] dackN;
  logic [7:0] dataOut;

  int nChecks = 0, nFails = 0, cycles = 0;
  int nMemr, nMemw, nIor, nIow, nTc, nOverlap, iorRun, iorLast;
  logic [3:0] dackSeen;
  logic [7:0] wrData;
  logic pMemr = 1, pMemw = 1, pIor = 1, pIow = 1;
  logic grantEn = 1;
  bit done = 0;

  always #2 clk = ~clk;

  dma_xfer_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .xferKind(xferKind), .demandMode(demandMode), .memToMem(memToMem),
    .hlda(hlda), .busWait(busWait), .eopInN(eopInN), .loadEn(loadEn),
    .loadChan(loadChan), .loadValue(loadValue), .dataIn(dataIn),
    .hreq(hreq), .memrN(memrN), .memwN(memwN), .iorN(iorN), .iowN(iowN),
    .dackN(dackN), .tcPulse(tcPulse), .dataOut(dataOut), .dataOe(dataOe)
  );

  // host model: acknowledge one cycle after request
  always @(negedge clk) hlda <= hreq && grantEn;

  // bus monitor
  always @(negedge clk) begin
    cycles++;
    if (memrN && !pMemr) begin nMemr++; dataIn = 8'h3C; end
    if (memwN && !pMemw) nMemw++;
    if (iowN && !pIow) nIow++;
    if (!iorN) iorRun++;
    if (iorN && !pIor) begin nIor++; iorLast = iorRun; iorRun = 0; end
    if (tcPulse) nTc++;
    if ((!memrN && !iorN) || (!memwN && !iowN)) nOverlap++;
    if (!memwN && dataOe) wrData = dataOut;
    dackSeen = dackSeen | ~dackN;
    pMemr = memrN; pMemw = memwN; pIor = iorN; pIow = iowN;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    nMemr = 0; nMemw = 0; nIor = 0; nIow = 0; nTc = 0; nOverlap = 0;
    iorRun = 0; iorLast = 0; dackSeen = 0; wrData = 0;
  endtask

  task automatic loadCount(input logic [1:0] ch, input logic [15:0] v);
    @(negedge clk); #1;
    loadEn = 1; loadChan = ch; loadValue = v;
    @(negedge clk); #1;
    loadEn = 0;
  endtask

  task automatic startReq(input logic [1:0] ch, input logic [1:0] kind, input logic dem, input logic m2m);
    @(negedge clk); #1;
    clearMon();
    reqChan = ch; xferKind = kind; demandMode = dem; memToMem = m2m; reqValid = 1;
  endtask

  // wait for hreq to rise, then fall; then withdraw request
  task automatic waitDone(input string req);
    int k;
    k = 0;
    while (!hreq && k < 50) begin @(negedge clk); #1; k++; end
    while (hreq && k < 500) begin @(negedge clk); #1; k++; end
    reqValid = 0;
    chk(!hreq, req, "run ended (hreq)", hreq, 0);
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk(!hreq, "R1", "hreq after reset", hreq, 0);
    chk({memrN, memwN, iorN, iowN} == 4'hF, "R1", "strobes after reset", {memrN, memwN, iorN, iowN}, 15);
    chk(dackN == 4'hF, "R1", "dackN after reset", dackN, 15);
    chk(!tcPulse && !dataOe, "R1", "tcPulse/dataOe after reset", {tcPulse, dataOe}, 0);
  endtask

  task automatic t_no_grant_drop();
    grantEn = 0;
    startReq(2'd0, 2'b01, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk(hreq, "R2", "hreq one cycle after request", hreq, 1);
    repeat (4) @(negedge clk);
    #1;
    chk({memrN, memwN, iorN, iowN} == 4'hF, "R2", "no strobe without hlda", {memrN, memwN, iorN, iowN}, 15);
    reqValid = 0;
    @(negedge clk); #1;
    chk(!hreq, "R3", "hreq falls after request dropped", hreq, 0);
    chk(nIor + nMemw == 0, "R3", "no transfer after drop", nIor + nMemw, 0);
    grantEn = 1;
  endtask

  task automatic t_single_mem2io();
    loadCount(2'd2, 16'd3);
    startReq(2'd2, 2'b10, 1'b0, 1'b0);
    waitDone("R6");
    chk(nMemr == 1 && nIow == 1, "R4", "mem->io strobes", nMemr * 10 + nIow, 11);
    chk(nIor == 0 && nMemw == 0, "R4", "mem->io unused strobes", nIor + nMemw, 0);
    chk(dackSeen == 4'b0100, "R4", "dack channel 2", dackSeen, 4);
    chk(nTc == 0, "R6", "single transfer no tc", nTc, 0);
  endtask

  task automatic t_demand_tc();
    loadCount(2'd0, 16'd2);
    startReq(2'd0, 2'b01, 1'b1, 1'b0);
    waitDone("R7");
    chk(nIor == 3 && nMemw == 3, "R7", "demand transfers for count 2", nMemw, 3);
    chk(nTc == 1, "R7", "one tc pulse", nTc, 1);
    chk(iorLast == 2, "R5", "strobe width without wait", iorLast, 2);
    chk(nOverlap == 0, "R11", "strobe overlap", nOverlap, 0);
  endtask

  task automatic t_wait();
    int k;
    loadCount(2'd3, 16'd5);
    busWait = 1;
    startReq(2'd3, 2'b01, 1'b0, 1'b0);
    k = 0;
    while (iorN && k < 50) begin @(negedge clk); #1; k++; end
    repeat (4) @(negedge clk);
    #1 busWait = 0;
    waitDone("R5");
    chk(iorLast == 5, "R5", "stretched strobe width", iorLast, 5);
  endtask

  task automatic t_req_drop_demand();
    int k;
    loadCount(2'd1, 16'd10);
    startReq(2'd1, 2'b01, 1'b1, 1'b0);
    k = 0;
    while (nMemw < 2 && k < 100) begin @(negedge clk); #1; k++; end
    reqValid = 0;
    waitDone("R8");
    chk(nMemw == 2, "R8", "transfers before request drop", nMemw, 2);
    chk(nTc == 0, "R8", "no tc on request drop", nTc, 0);
  endtask

  task automatic t_eop();
    int k;
    loadCount(2'd1, 16'd10);
    startReq(2'd1, 2'b01, 1'b1, 1'b0);
    k = 0;
    while (!hreq && k < 20) begin @(negedge clk); #1; k++; end
    eopInN = 0;
    @(negedge clk); #1 eopInN = 1;
    waitDone("R8");
    chk(nMemw == 1, "R8", "transfers after eop", nMemw, 1);
    chk(nTc == 0, "R8", "no tc on eop", nTc, 0);
  endtask

  task automatic t_verify_illegal();
    loadCount(2'd3, 16'd0);
    startReq(2'd3, 2'b00, 1'b0, 1'b0);
    waitDone("R4");
    chk(nMemr + nMemw + nIor + nIow == 0, "R4", "verify drives no strobe", nMemr + nMemw + nIor + nIow, 0);
    chk(nTc == 1, "R4", "verify decrements count to tc", nTc, 1);
    loadCount(2'd2, 16'd0);
    startReq(2'd2, 2'b11, 1'b1, 1'b0);
    waitDone("R9");
    chk(nMemr + nMemw + nIor + nIow == 0, "R9", "illegal kind no strobe", nMemr + nMemw + nIor + nIow, 0);
    chk(nTc == 0 && dackSeen == 0, "R9", "illegal kind no count/dack", nTc + dackSeen, 0);
    // count of ch2 still 0: one demand transfer then tc
    startReq(2'd2, 2'b01, 1'b1, 1'b0);
    waitDone("R9");
    chk(nMemw == 1 && nTc == 1, "R9", "count unchanged by illegal", nMemw, 1);
  endtask

  task automatic t_copy();
    loadCount(2'd1, 16'd0);
    dataIn = 8'hA5;
    startReq(2'd0, 2'b00, 1'b0, 1'b1);
    waitDone("R10");
    chk(nMemr == 1 && nMemw == 1, "R10", "copy read/write strobes", nMemr * 10 + nMemw, 11);
    chk(wrData == 8'hA5, "R10", "copied byte", wrData, 8'hA5);
    chk(nTc == 1, "R10", "channel 1 tc", nTc, 1);
    chk(nIor + nIow == 0, "R10", "no I/O strobes in copy", nIor + nIow, 0);
    loadCount(2'd1, 16'd2);
    startReq(2'd0, 2'b00, 1'b0, 1'b1);
    waitDone("R10");
    chk(nMemw == 3 && nTc == 1, "R10", "copy repeats to ch1 tc", nMemw, 3);
  endtask

  task automatic t_load_busy();
    int k;
    loadCount(2'd2, 16'd1);
    startReq(2'd2, 2'b01, 1'b0, 1'b0);
    k = 0;
    while (iorN && k < 50) begin @(negedge clk); #1; k++; end
    loadEn = 1; loadChan = 2'd2; loadValue = 16'd5;
    @(negedge clk); #1 loadEn = 0;
    waitDone("R12");
    startReq(2'd2, 2'b01, 1'b1, 1'b0);
    waitDone("R12");
    chk(nMemw == 1 && nTc == 1, "R12", "busy load ignored", nMemw, 1);
  endtask

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk); #1;
    t_reset();
    t_no_grant_drop();
    t_single_mem2io();
    t_demand_tc();
    t_wait();
    t_req_drop_demand();
    t_eop();
    t_verify_illegal();
    t_copy();
    t_load_busy();
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) @(negedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule